// File: doc/BRIEF.md
# EDO DRAM Cycle Controller

This block sits between a synchronous host and an asynchronous 1M x 16 EDO dynamic RAM. It takes one word request at a time and runs one complete memory cycle for it. The 20-bit word address goes out on one 10-bit pin bus: the row first, then the column. The controller drives the row-strobe, the two byte-lane column strobes, the write strobe and the output-enable pins. Each strobe interval is a count of clock cycles set by a parameter. The controller holds the strobe low for at least the minimum active time and high for at least the minimum precharge time.

Writes are early writes. The write strobe is already low before any column strobe falls. The controller drives the 16-bit data bus for the whole time the row strobe is low, so the bus never changes direction in the middle of a cycle. Reads keep the write strobe high and the output enable low while the column strobes are active. The controller samples the bus after a parameterised number of cycles and returns the word with a one-cycle response pulse. A built-in interval timer asks for a CAS-before-RAS refresh. That refresh is served before any waiting host request.

The request port uses valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `req_ready` is high only while the controller is idle with no refresh waiting. The host may hold `req_valid` and the request fields for any number of cycles. The response port has no back-pressure: the host must take `rsp_data` in the single cycle that `rsp_valid` is high.

Top module: `edo_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it ends, the row strobe, both column strobes, the write strobe and the output enable are high, `rsp_valid` is low and `req_ready` is high.
- R2: The row strobe falls with `req_addr[19:10]` on `mem_addr`. A column strobe later falls with `req_addr[9:0]` on `mem_addr`.
- R3: Every low period of the row strobe lasts at least T_RAS clock cycles.
- R4: Every high period of the row strobe between two cycles lasts at least T_RP clock cycles.
- R5: In a read, the write strobe stays high and both column strobes fall. `rsp_valid` then pulses for exactly one cycle with the stored word on `rsp_data`.
- R6: In a write, the write strobe is low at least one cycle before a column strobe falls. The output enable stays high, and the write data is driven on `mem_dq` while the row strobe is low.
- R7: In a write, `mem_ucas_n` pulses only if `req_be[1]` (bits 15:8) is set, and `mem_lcas_n` pulses only if `req_be[0]` (bits 7:0) is set. The lane that is not enabled keeps its old contents.
- R8: Once a column strobe is low, `mem_addr` holds the column value until the row strobe rises.
- R9: Every REF_INTERVAL cycles the controller runs a refresh. Both column strobes go low at least one cycle before the row strobe falls, the write strobe stays high, and the R3 and R4 minimums apply.
- R10: A waiting refresh takes priority over a waiting host request. Refreshes still occur while the host keeps `req_valid` high without a break.
- R11: `req_ready` is high only when all strobes are idle. It drops in the cycle after a request is taken and stays low until that cycle has finished its precharge.
- R12: A write with both byte enables clear runs a row-strobe-only cycle. No column strobe falls, and memory contents are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 20 | Word address, row in bits 19:10 and column in bits 9:0 |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, bit 1 upper lane, bit 0 lower lane |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_data | output | 16 | Read data |
| mem_ras_n | output | 1 | Row strobe, active low |
| mem_ucas_n | output | 1 | Upper-lane column strobe, active low |
| mem_lcas_n | output | 1 | Lower-lane column strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_addr | output | 10 | Multiplexed row/column address |
| mem_dq | inout | 16 | Bidirectional data bus |

## Verification
The bench writes distinct patterns to the four address corners: all zeros, all ones, row zero with column maximum, and row maximum with column zero. Reading these back shows whether the row and column halves are swapped or truncated. The bench then overwrites single lanes with one byte enable, and writes once with both byte enables clear. The readback shows whether the lane strobes are mapped correctly, whether the untouched byte survives, and whether a write with no lanes changes nothing. A behavioural memory model checks the strobe intervals and the refresh ordering on every cycle. One long idle stretch and one back-to-back request stream show that refresh is issued on time and is not starved by host traffic.

// File: rtl/edo_pkg.sv
package edo_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_COL,
    ST_HOLD,
    ST_PRE,
    ST_RCAS,
    ST_RRAS
  } edo_state_e;

  typedef struct packed {
    logic ras_n;
    logic ucas_n;
    logic lcas_n;
    logic we_n;
    logic oe_n;
    logic drive;
  } edo_strobe_t;

  function automatic logic ras_active(input edo_state_e s);
    return (s == ST_ROW) || (s == ST_COL) || (s == ST_HOLD) || (s == ST_RRAS);
  endfunction

endpackage

// File: rtl/edo_wait_cnt.sv
module edo_wait_cnt #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= load_val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/edo_refresh_timer.sv
module edo_refresh_timer #(
  parameter int INTERVAL = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  output logic pend
);
  localparam int TW = $clog2(INTERVAL + 1);
  localparam logic [TW-1:0] LAST = TW'(INTERVAL - 1);

  logic [TW-1:0] tick_q;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tick_q <= '0;
      pend_q <= 1'b0;
    end else begin
      if (tick_q == LAST) begin
        tick_q <= '0;
        pend_q <= 1'b1;
      end else begin
        tick_q <= tick_q + 1'b1;
        if (ack) pend_q <= 1'b0;
      end
    end
  end

  assign pend = pend_q;
endmodule

// File: rtl/edo_pin_decode.sv
module edo_pin_decode
  import edo_pkg::*;
#(
  parameter int LANES = 2
) (
  input  edo_state_e       state,
  input  logic             wr,
  input  logic [LANES-1:0] be,
  output edo_strobe_t      pins
);
  logic [LANES-1:0] lane_low;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    always_comb begin
      unique case (state)
        ST_COL, ST_HOLD: lane_low[i] = wr ? be[i] : 1'b1;
        ST_RCAS, ST_RRAS: lane_low[i] = 1'b1;
        default:          lane_low[i] = 1'b0;
      endcase
    end
  end

  always_comb begin
    pins.ras_n  = !ras_active(state);
    pins.ucas_n = !lane_low[LANES-1];
    pins.lcas_n = !lane_low[0];
    pins.we_n   = 1'b1;
    pins.oe_n   = 1'b1;
    pins.drive  = 1'b0;
    if (state == ST_ROW || state == ST_COL || state == ST_HOLD) begin
      pins.we_n  = !wr;
      pins.drive = wr;
      if (state != ST_ROW) pins.oe_n = wr;
    end
  end
endmodule

// File: rtl/edo_seq.sv
module edo_seq
  import edo_pkg::*;
#(
  parameter int AW     = 20,
  parameter int DW     = 16,
  parameter int LANES  = 2,
  parameter int T_RCD  = 2,
  parameter int T_CAC  = 2,
  parameter int T_RAS  = 6,
  parameter int T_RP   = 4,
  parameter int T_CSR  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_wdata,
  input  logic [LANES-1:0] req_be,
  input  logic             ref_pend,
  output logic             ref_ack,
  input  logic [DW-1:0]    dq_in,
  output edo_state_e       state,
  output logic             wr_q,
  output logic [LANES-1:0] be_q,
  output logic [AW-1:0]    addr_q,
  output logic [DW-1:0]    wdata_q,
  output logic             rsp_valid,
  output logic [DW-1:0]    rsp_data
);
  localparam int MAXT = (T_RCD > T_CAC ? T_RCD : T_CAC) > (T_RP > T_CSR ? T_RP : T_CSR)
                        ? (T_RCD > T_CAC ? T_RCD : T_CAC) : (T_RP > T_CSR ? T_RP : T_CSR);
  localparam int CW = $clog2(MAXT + 1);
  localparam int AC = $clog2(T_RAS + 1);
  localparam logic [AC-1:0] ACT_LAST = AC'(T_RAS - 1);
  localparam logic [AC-1:0] ACT_SAT  = AC'(T_RAS);

  edo_state_e    st_q, st_d;
  logic          wait_zero;
  logic          load;
  logic [CW-1:0] load_val;
  logic [AC-1:0] act_q;
  logic          take;
  logic          act_done;

  assign req_ready = (st_q == ST_IDLE) && !ref_pend;
  assign take      = req_valid && req_ready;
  assign act_done  = (act_q >= ACT_LAST);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: begin
        if (ref_pend)       st_d = ST_RCAS;
        else if (req_valid) st_d = ST_ROW;
      end
      ST_ROW:  if (wait_zero) st_d = ST_COL;
      ST_COL:  if (wait_zero) st_d = ST_HOLD;
      ST_HOLD: if (act_done)  st_d = ST_PRE;
      ST_RCAS: if (wait_zero) st_d = ST_RRAS;
      ST_RRAS: if (act_done)  st_d = ST_PRE;
      ST_PRE:  if (wait_zero) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  assign ref_ack = (st_q == ST_IDLE) && ref_pend;

  always_comb begin
    load     = (st_d != st_q);
    load_val = '0;
    unique case (st_d)
      ST_ROW:  load_val = CW'(T_RCD - 1);
      ST_COL:  load_val = CW'(T_CAC - 1);
      ST_PRE:  load_val = CW'(T_RP - 1);
      ST_RCAS: load_val = CW'(T_CSR - 1);
      default: load_val = '0;
    endcase
  end

  edo_wait_cnt #(.CW(CW)) u_wait (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .zero     (wait_zero)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      act_q     <= '0;
      wr_q      <= 1'b0;
      be_q      <= '0;
      addr_q    <= '0;
      wdata_q   <= '0;
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      st_q <= st_d;
      if (ras_active(st_q) && ras_active(st_d)) begin
        if (act_q != ACT_SAT) act_q <= act_q + 1'b1;
      end else begin
        act_q <= '0;
      end
      if (take) begin
        wr_q    <= req_write;
        be_q    <= req_be;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_valid <= 1'b0;
      if (st_q == ST_COL && wait_zero && !wr_q) begin
        rsp_valid <= 1'b1;
        rsp_data  <= dq_in;
      end
    end
  end

  assign state = st_q;
endmodule

// File: rtl/edo_ctrl.sv
module edo_ctrl
  import edo_pkg::*;
#(
  parameter int ROW_W        = 10,
  parameter int COL_W        = 10,
  parameter int DATA_W       = 16,
  parameter int T_RCD        = 2,
  parameter int T_CAC        = 2,
  parameter int T_RAS        = 6,
  parameter int T_RP         = 4,
  parameter int T_CSR        = 1,
  parameter int REF_INTERVAL = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic                   req_write,
  input  logic [ROW_W+COL_W-1:0] req_addr,
  input  logic [DATA_W-1:0]      req_wdata,
  input  logic [DATA_W/8-1:0]    req_be,
  output logic                   rsp_valid,
  output logic [DATA_W-1:0]      rsp_data,
  output logic                   mem_ras_n,
  output logic                   mem_ucas_n,
  output logic                   mem_lcas_n,
  output logic                   mem_we_n,
  output logic                   mem_oe_n,
  output logic [ROW_W-1:0]       mem_addr,
  inout  wire  [DATA_W-1:0]      mem_dq
);
  localparam int AW    = ROW_W + COL_W;
  localparam int LANES = DATA_W / 8;

  edo_state_e       state;
  logic             wr_q;
  logic [LANES-1:0] be_q;
  logic [AW-1:0]    addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic             ref_pend;
  logic             ref_ack;
  edo_strobe_t      pins;
  logic [ROW_W-1:0] col_ext;

  edo_refresh_timer #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .ack   (ref_ack),
    .pend  (ref_pend)
  );

  edo_seq #(
    .AW(AW), .DW(DATA_W), .LANES(LANES),
    .T_RCD(T_RCD), .T_CAC(T_CAC), .T_RAS(T_RAS), .T_RP(T_RP), .T_CSR(T_CSR)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_be    (req_be),
    .ref_pend  (ref_pend),
    .ref_ack   (ref_ack),
    .dq_in     (mem_dq),
    .state     (state),
    .wr_q      (wr_q),
    .be_q      (be_q),
    .addr_q    (addr_q),
    .wdata_q   (wdata_q),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_data)
  );

  edo_pin_decode #(.LANES(LANES)) u_dec (
    .state (state),
    .wr    (wr_q),
    .be    (be_q),
    .pins  (pins)
  );

  assign col_ext = ROW_W'(addr_q[COL_W-1:0]);

  always_comb begin
    if (state == ST_COL || state == ST_HOLD) mem_addr = col_ext;
    else                                     mem_addr = addr_q[AW-1:COL_W];
  end

  assign mem_ras_n  = pins.ras_n;
  assign mem_ucas_n = pins.ucas_n;
  assign mem_lcas_n = pins.lcas_n;
  assign mem_we_n   = pins.we_n;
  assign mem_oe_n   = pins.oe_n;
  assign mem_dq     = pins.drive ? wdata_q : {DATA_W{1'bz}};
endmodule

// File: rtl/edo_ctrl_chk.sv
module edo_ctrl_chk #(
  parameter int ROW_W = 10,
  parameter int T_RAS = 6,
  parameter int T_RP  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mem_ras_n,
  input logic             mem_ucas_n,
  input logic             mem_lcas_n,
  input logic             mem_we_n,
  input logic             mem_oe_n,
  input logic [ROW_W-1:0] mem_addr,
  input logic             req_ready,
  input logic             rsp_valid
);
  logic [15:0] lo_q, hi_q;
  logic        cas_any;

  assign cas_any = !mem_ucas_n || !mem_lcas_n;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= 16'(T_RP);
    end else begin
      lo_q <= mem_ras_n ? '0 : ((lo_q == 16'hFFFF) ? lo_q : lo_q + 1'b1);
      hi_q <= !mem_ras_n ? '0 : ((hi_q == 16'hFFFF) ? hi_q : hi_q + 1'b1);
    end
  end

  p_ras_min_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_ras_n) |-> lo_q >= 16'(T_RAS));

  p_pre_min_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ras_n) |-> hi_q >= 16'(T_RP));

  p_read_we_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> mem_we_n);

  p_rsp_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_write_oe_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);

  p_early_we_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (($fell(mem_ucas_n) || $fell(mem_lcas_n)) && !mem_we_n) |-> !$past(mem_we_n));

  p_col_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ras_n && cas_any && $past(!mem_ras_n && cas_any)) |-> $stable(mem_addr));

  p_cbr_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(mem_ras_n) && cas_any) |-> ($past(!mem_ucas_n && !mem_lcas_n) && mem_we_n));

  p_ready_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (mem_ras_n && mem_ucas_n && mem_lcas_n));
endmodule

bind edo_ctrl edo_ctrl_chk #(.ROW_W(ROW_W), .T_RAS(T_RAS), .T_RP(T_RP)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mem_ras_n  (mem_ras_n),
  .mem_ucas_n (mem_ucas_n),
  .mem_lcas_n (mem_lcas_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_addr   (mem_addr),
  .req_ready  (req_ready),
  .rsp_valid  (rsp_valid)
);

// File: tb/tb_edo_ctrl.sv
module tb_edo_ctrl;
  localparam int T_RAS = 6;
  localparam int T_RP  = 4;
  localparam int REF_INTERVAL = 200;
  localparam int WDOG = 150000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [19:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_be = '0;
  logic        rsp_valid;
  logic [15:0] rsp_data;
  logic        ras_n, ucas_n, lcas_n, we_n, oe_n;
  logic [9:0]  maddr;
  wire  [15:0] dq;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  edo_ctrl #(.T_RAS(T_RAS), .T_RP(T_RP), .REF_INTERVAL(REF_INTERVAL)) dut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .mem_ras_n(ras_n), .mem_ucas_n(ucas_n), .mem_lcas_n(lcas_n),
    .mem_we_n(we_n), .mem_oe_n(oe_n), .mem_addr(maddr), .mem_dq(dq)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // behavioural memory model
  logic [15:0] store [logic [19:0]];
  logic [9:0]  m_row = '0, m_col = '0;
  logic [15:0] m_word = '0;
  logic        p_ras = 1'b1, p_ucas = 1'b1, p_lcas = 1'b1, p_we = 1'b1;
  int          lo_cnt = 0, hi_cnt = 1000, ref_cnt = 0;
  bit          in_ref = 1'b0, cas_seen = 1'b0;
  logic [9:0]  last_row = '0, last_col = '0;
  logic        m_drive;

  assign m_drive = !ras_n && !oe_n && we_n && (!ucas_n || !lcas_n);
  assign dq = m_drive ? m_word : 16'hzzzz;

  always @(negedge clk) begin
    if (rst_n) begin
      if (p_ras && !ras_n) begin
        check(hi_cnt >= T_RP, "R4 precharge", hi_cnt, T_RP);
        if (!ucas_n || !lcas_n) begin
          in_ref = 1'b1;
          ref_cnt++;
          check(!p_ucas && !p_lcas && we_n, "R9 cbr order", {p_ucas, p_lcas, we_n}, 3'b001);
        end else begin
          in_ref = 1'b0;
          cas_seen = 1'b0;
          m_row = maddr;
          last_row = maddr;
        end
      end
      if (!p_ras && ras_n)
        check(lo_cnt >= T_RAS, "R3 active", lo_cnt, T_RAS);
      if (!ras_n && !in_ref) begin
        if ((p_ucas && !ucas_n) || (p_lcas && !lcas_n)) begin
          m_col = maddr;
          last_col = maddr;
          cas_seen = 1'b1;
          if (!we_n) begin
            check(!p_we, "R6 early we", p_we, 0);
            if (!store.exists({m_row, m_col})) store[{m_row, m_col}] = '0;
            if (!ucas_n) store[{m_row, m_col}][15:8] = dq[15:8];
            if (!lcas_n) store[{m_row, m_col}][7:0]  = dq[7:0];
          end
          m_word = store.exists({m_row, m_col}) ? store[{m_row, m_col}] : 16'h0000;
        end else if (cas_seen && (!ucas_n || !lcas_n) && maddr != m_col) begin
          check(1'b0, "R8 column hold", maddr, m_col);
        end
        if (!we_n && (^dq === 1'bx))
          check(1'b0, "R6 write drive", dq, 0);
      end
      if (!ras_n) begin lo_cnt++; hi_cnt = 0; end
      else begin hi_cnt++; lo_cnt = 0; end
    end
    p_ras = ras_n; p_ucas = ucas_n; p_lcas = lcas_n; p_we = we_n;
  end

  task automatic do_req(input logic wr, input logic [1:0] be, input logic [19:0] a,
                        input logic [15:0] d, input logic [15:0] exp_d);
    int n;
    n = 0;
    while (!req_ready) begin @(negedge clk); n++; if (n > 1000) break; end
    req_valid = 1'b1; req_write = wr; req_be = be; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    check(!req_ready, "R11 ready drop", req_ready, 0);
    if (!wr) begin
      n = 0;
      while (!rsp_valid && n < 40) begin @(negedge clk); n++; end
      check(rsp_data == exp_d, "R5 read data", rsp_data, exp_d);
      @(negedge clk);
      check(!rsp_valid, "R5 single pulse", rsp_valid, 0);
    end
    n = 0;
    while (!req_ready && n < 100) begin @(negedge clk); n++; end
    if (!(wr && be == 2'b00)) begin
      check(last_row == a[19:10], "R2 row", last_row, a[19:10]);
      check(last_col == a[9:0], "R2 column", last_col, a[9:0]);
    end
  endtask

  // {write, be, addr, wdata, expected read}
  localparam int NV = 13;
  localparam logic [54:0] VEC [NV] = '{
    {1'b1, 2'b11, 20'h00000, 16'hA5A5, 16'h0000},
    {1'b1, 2'b11, 20'hFFFFF, 16'h1234, 16'h0000},
    {1'b1, 2'b11, 20'h003FF, 16'h0F0F, 16'h0000},
    {1'b1, 2'b11, 20'hFFC00, 16'hC3C3, 16'h0000},
    {1'b0, 2'b11, 20'h00000, 16'h0000, 16'hA5A5},
    {1'b0, 2'b11, 20'hFFFFF, 16'h0000, 16'h1234},
    {1'b1, 2'b01, 20'h00000, 16'hEE77, 16'h0000},  // R7 lower only
    {1'b1, 2'b10, 20'hFFFFF, 16'h99EE, 16'h0000},  // R7 upper only
    {1'b1, 2'b00, 20'h003FF, 16'hFFFF, 16'h0000},  // R12 no lanes
    {1'b0, 2'b11, 20'h00000, 16'h0000, 16'hA577},
    {1'b0, 2'b11, 20'hFFFFF, 16'h0000, 16'h9934},
    {1'b0, 2'b11, 20'h003FF, 16'h0000, 16'h0F0F},
    {1'b0, 2'b11, 20'hFFC00, 16'h0000, 16'hC3C3}
  };

  initial begin
    int r0;
    int cas_falls;
    repeat (3) @(negedge clk);
    check({ras_n, ucas_n, lcas_n, we_n, oe_n} == 5'h1F, "R1 strobes in reset",
          {ras_n, ucas_n, lcas_n, we_n, oe_n}, 5'h1F);
    check(!rsp_valid, "R1 rsp low", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready, "R1 ready after reset", req_ready, 1);
    check({ras_n, ucas_n, lcas_n, we_n, oe_n} == 5'h1F, "R1 idle strobes",
          {ras_n, ucas_n, lcas_n, we_n, oe_n}, 5'h1F);

    for (int i = 0; i < NV; i++)
      do_req(VEC[i][54], VEC[i][53:52], VEC[i][51:32], VEC[i][31:16], VEC[i][15:0]);

    // R12: a no-lane write shows no column strobe at all
    cas_falls = 0;
    fork
      do_req(1'b1, 2'b00, 20'h00000, 16'h0000, 16'h0000);
      begin
        for (int k = 0; k < 30; k++) begin
          @(negedge clk);
          if (!ras_n && !in_ref && (!ucas_n || !lcas_n)) cas_falls++;
        end
      end
    join
    check(cas_falls == 0, "R12 no cas", cas_falls, 0);
    do_req(1'b0, 2'b11, 20'h00000, 16'h0000, 16'hA577);

    // R9: refresh cadence while idle
    r0 = ref_cnt;
    repeat (5 * REF_INTERVAL) @(negedge clk);
    check(ref_cnt - r0 >= 4, "R9 refresh count", ref_cnt - r0, 4);

    // R10: refresh not starved by back-to-back host traffic
    r0 = ref_cnt;
    for (int k = 0; k < 60; k++)
      do_req(1'b0, 2'b11, 20'hFFC00, 16'h0000, 16'hC3C3);
    check(ref_cnt - r0 >= 2, "R10 refresh under load", ref_cnt - r0, 2);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc >= WDOG || done);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, WDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule